// File: doc/BRIEF.md
# Page Write Collector with Self-Timed Commit

This block sits between the serial bus engine of a small byte-addressed non-volatile memory and the memory array's write port. While a write transaction is open, the bus engine hands it one received data byte at a time. The block holds those bytes in a page latch of `SLOTS` entries. Each entry has a valid flag, so only the bytes that actually arrived are later written. The first byte of a transaction sets the page, from the upper address bits, and the starting slot. After that, only the slot index moves, and it wraps inside the page. Extra bytes therefore overwrite earlier ones in first-in, first-out order.

Nothing reaches the array until the bus engine signals the STOP that closes the transaction. From that STOP, the block raises `busy` for exactly `CYC_CLKS` clocks, which is the self-timed programming window. During that window the bus engine must refuse every acknowledge. In the first `SLOTS` clocks of the window the block scans the slots in ascending order and writes each valid byte to the array. An abort, such as a repeated START or a protocol error, empties the latch and writes nothing. In every case, the address pointer the engine uses for later current-address reads is reported on `ptr`.

Top module: `pgwr_buf`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `mem_we` is 0 and `ptr` is 0.
- R2: A load into an empty latch takes the page from `ld_addr[AW-1:3]` and the slot from `ld_addr[2:0]`. The `ld_addr` of every later load in the same transaction is ignored. Each load advances only the 3-bit slot index by one, and the page bits stay fixed.
- R3: Loading more than 8 bytes wraps the slot index from 7 to 0. Each new byte overwrites the byte already held in its slot.
- R4: The array is not written before a commit. A commit with at least one valid byte raises `busy` on the next clock and holds it for exactly `CYC_CLKS` clocks.
- R5: During the first 8 clocks of the busy window, busy clock k (k = 0..7) asserts `mem_we` only if slot k is valid. The address is `{page, k}` and the data is the byte held in slot k. No other writes occur.
- R6: An abort clears all valid flags without writing. `ptr` then shows `{page, slot}`, the address after the last loaded byte.
- R7: Load, commit and abort strobes that arrive while `busy` is 1 have no effect.
- R8: A commit with no valid byte does not raise `busy` and writes nothing.
- R9: After a commit completes, `ptr` equals the address after the last loaded byte under the page wrap rule, for example 0x25 plus 3 bytes gives 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_stb | input | 1 | One-clock strobe: a data byte was received |
| ld_byte | input | DW | Received data byte |
| ld_addr | input | AW | Word address; used only when the latch is empty |
| commit_stb | input | 1 | One-clock strobe: STOP ended the write transaction |
| abort_stb | input | 1 | One-clock strobe: drop the transaction without writing |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | DW | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| ptr | output | AW | Current address pointer for the bus engine |

## Verification
The main function is exercised with four kinds of transaction:
- A single byte in mid-page shows that one valid flag yields exactly one write and that the pointer steps by one.
- A three-byte run that ends on the last slot separates page-local wrap of the pointer from a plain increment.
- A ten-byte run that starts at slot 6 shows that the two wrapped bytes replace the first two and that the array sees all eight slots in slot order.
- An aborted two-byte run, and strobes sent during the busy window, show that no write and no change of pointer can come from them.

// File: rtl/pgwr_pkg.sv
// Package: shared helpers for the page write collector.
// Assumes callers pass positive cycle counts.
package pgwr_pkg;

    // Width of a counter that must hold values 0..cyc-1, at least 1 bit.
    function automatic int unsigned cnt_width(input int unsigned cyc);
        int unsigned w;
        w = $clog2(cyc);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/pgwr_latch.sv
// Module: pgwr_latch
// Holds the page bytes, their valid flags, the page number and the slot index.
// Assumes at most one strobe per cycle. Priority while idle:
// abort > commit > load. All strobes are ignored while busy.
module pgwr_latch #(
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 8,
    parameter int unsigned SLOTS = 8,
    localparam int unsigned SW   = $clog2(SLOTS),
    localparam int unsigned PW   = AW - SW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld,
    input  logic [DW-1:0]             ld_byte,
    input  logic [AW-1:0]             ld_addr,
    input  logic                      commit,
    input  logic                      abort,
    input  logic                      busy,
    input  logic                      done,
    output logic                      go,
    output logic [SLOTS-1:0]          mask,
    output logic [SLOTS-1:0][DW-1:0]  pg,
    output logic [PW-1:0]             page,
    output logic [SW-1:0]             slot
);

    logic empty;
    logic [SW-1:0] ld_slot;

    assign empty   = (mask == '0);
    assign ld_slot = empty ? ld_addr[SW-1:0] : slot;

    // Commit request is accepted only when idle, not aborting, and something is held.
    assign go = commit && !busy && !abort && !empty;

    // Fill slots, keep valid flags, clear them on abort or at the end of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            pg   <= '0;
            page <= '0;
            slot <= '0;
        end else if (done) begin
            mask <= '0;
        end else if (!busy) begin
            if (abort) begin
                mask <= '0;
            end else if (ld && !commit) begin
                if (empty) begin
                    page <= ld_addr[AW-1:SW];
                end
                pg[ld_slot]   <= ld_byte;
                mask[ld_slot] <= 1'b1;
                slot          <= ld_slot + SW'(1);
            end
        end
    end

    // R7: valid flags are frozen for the whole busy window.
    a_r7_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mask));

    // R2: the page number stays fixed while a transaction holds bytes.
    a_r2_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        ((|$past(mask)) && (|mask)) |-> $stable(page));

endmodule

// File: rtl/pgwr_timer.sv
// Module: pgwr_timer
// Self-timed write window. It starts on go and lasts CYC_CLKS clocks.
// The elapsed count is exported so the write port can scan slots.
// Assumes CYC_CLKS >= number of page slots.
module pgwr_timer #(
    parameter int unsigned CYC_CLKS = 1_000_000,
    parameter int unsigned CW       = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] LAST = CW'(CYC_CLKS - 1);

    assign done = busy && (cnt == LAST);

    // Count busy clocks and drop busy after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end else if (go) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end

    // R4: busy only begins in the clock after an accepted commit.
    a_r4_busy_from_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

    // R4: the count never passes the programmed window.
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= LAST));

endmodule

// File: rtl/pgwr_port.sv
// Module: pgwr_port
// Drives the array write port. Busy clock k, for k below SLOTS, writes slot k
// if it is valid. Purely combinational; it relies on the latch keeping
// mask and data stable while busy.
module pgwr_port #(
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 8,
    parameter int unsigned SLOTS = 8,
    parameter int unsigned CW    = 20,
    localparam int unsigned SW   = $clog2(SLOTS),
    localparam int unsigned PW   = AW - SW
) (
    input  logic                      busy,
    input  logic [CW-1:0]             cnt,
    input  logic [SLOTS-1:0]          mask,
    input  logic [SLOTS-1:0][DW-1:0]  pg,
    input  logic [PW-1:0]             page,
    output logic                      mem_we,
    output logic [AW-1:0]             mem_addr,
    output logic [DW-1:0]             mem_wdata
);

    logic          in_scan;
    logic [SW-1:0] idx;

    assign in_scan = busy && (cnt < CW'(SLOTS));
    assign idx     = cnt[SW-1:0];

    // Select the scanned slot and gate the enable by its valid flag.
    always_comb begin
        mem_we    = in_scan && mask[idx];
        mem_addr  = {page, idx};
        mem_wdata = pg[idx];
    end

endmodule

// File: rtl/pgwr_buf.sv
// Module: pgwr_buf (top)
// Page write collector with a self-timed commit. It gathers bytes from the
// bus engine, writes them to the array after STOP and holds busy for
// CYC_CLKS clocks. Assumes SLOTS is a power of two and CYC_CLKS >= SLOTS.
module pgwr_buf
    import pgwr_pkg::*;
#(
    parameter int unsigned AW       = 8,
    parameter int unsigned DW       = 8,
    parameter int unsigned SLOTS    = 8,
    parameter int unsigned CYC_CLKS = 1_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_stb,
    input  logic [DW-1:0] ld_byte,
    input  logic [AW-1:0] ld_addr,
    input  logic          commit_stb,
    input  logic          abort_stb,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic [AW-1:0] ptr
);

    localparam int unsigned SW = $clog2(SLOTS);
    localparam int unsigned PW = AW - SW;
    localparam int unsigned CW = cnt_width(CYC_CLKS) + 1;

    logic                     go;
    logic                     done;
    logic [CW-1:0]            cnt;
    logic [SLOTS-1:0]         mask;
    logic [SLOTS-1:0][DW-1:0] pg;
    logic [PW-1:0]            page;
    logic [SW-1:0]            slot;

    pgwr_latch #(.AW(AW), .DW(DW), .SLOTS(SLOTS)) u_latch (
        .clk(clk), .rst_n(rst_n), .ld(ld_stb), .ld_byte(ld_byte),
        .ld_addr(ld_addr), .commit(commit_stb), .abort(abort_stb),
        .busy(busy), .done(done), .go(go), .mask(mask), .pg(pg),
        .page(page), .slot(slot)
    );

    pgwr_timer #(.CYC_CLKS(CYC_CLKS), .CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done), .cnt(cnt)
    );

    pgwr_port #(.AW(AW), .DW(DW), .SLOTS(SLOTS), .CW(CW)) u_port (
        .busy(busy), .cnt(cnt), .mask(mask), .pg(pg), .page(page),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // Pointer reported to the bus engine: page plus next slot.
    assign ptr = {page, slot};

    // R5: the array is written only inside the busy window.
    a_r5_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

endmodule

// File: tb/pgwr_buf_tb.sv
module pgwr_buf_tb;

    localparam int CLK_NS = 10;
    localparam int CYC    = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_stb = 1'b0;
    logic [7:0] ld_byte = '0;
    logic [7:0] ld_addr = '0;
    logic       commit_stb = 1'b0;
    logic       abort_stb = 1'b0;
    logic       mem_we;
    logic [7:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       busy;
    logic [7:0] ptr;

    int total = 0;
    int bad = 0;
    int busy_seen = 0;
    bit finished = 1'b0;
    logic [15:0] expq[$];

    always #(CLK_NS/2) clk = ~clk;

    pgwr_buf #(.AW(8), .DW(8), .SLOTS(8), .CYC_CLKS(CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_byte(ld_byte),
        .ld_addr(ld_addr), .commit_stb(commit_stb), .abort_stb(abort_stb),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .ptr(ptr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pop expected writes and compare; count busy clocks.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R5", "unexpected write addr", int'(mem_addr), -1);
            end else begin
                logic [15:0] e;
                e = expq.pop_front();
                chk({mem_addr, mem_wdata} == e, "R5", "write addr/data",
                    int'({mem_addr, mem_wdata}), int'(e));
            end
        end
        if (rst_n && busy) busy_seen++;
    end

    task automatic load(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_stb = 1'b1; ld_addr = a; ld_byte = d;
        @(negedge clk);
        ld_stb = 1'b0;
    endtask

    task automatic pulse_commit();
        @(negedge clk); commit_stb = 1'b1;
        @(negedge clk); commit_stb = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort_stb = 1'b1;
        @(negedge clk); abort_stb = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Commit, then check window length, drained queue and final pointer.
    task automatic commit_and_check(input logic [7:0] exp_ptr);
        busy_seen = 0;
        pulse_commit();
        chk(busy == 1'b1, "R4", "busy after commit", int'(busy), 1);
        wait_idle();
        chk(busy_seen == CYC, "R4", "busy length", busy_seen, CYC);
        chk(expq.size() == 0, "R5", "missing writes", expq.size(), 0);
        chk(ptr == exp_ptr, "R9", "pointer after commit", int'(ptr), int'(exp_ptr));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R4", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(mem_we == 1'b0, "R1", "mem_we in reset", int'(mem_we), 0);
        chk(ptr == 8'h00, "R1", "ptr in reset", int'(ptr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5: single byte write
        load(8'h13, 8'hA5);
        chk(busy == 1'b0, "R4", "no busy before commit", int'(busy), 0);
        expq.push_back({8'h13, 8'hA5});
        commit_and_check(8'h14);

        // R2 R9: three bytes ending on slot 7; later addresses ignored
        load(8'h25, 8'h01);
        load(8'hF0, 8'h02);
        load(8'h00, 8'h03);
        chk(ptr == 8'h20, "R2", "pointer wraps in page", int'(ptr), 8'h20);
        expq.push_back({8'h25, 8'h01});
        expq.push_back({8'h26, 8'h02});
        expq.push_back({8'h27, 8'h03});
        commit_and_check(8'h20);

        // R3: ten bytes from slot 6, slots 6 and 7 overwritten
        for (int i = 0; i < 10; i++) load(8'h46, 8'h30 + 8'(i));
        for (int s = 0; s < 8; s++) begin
            int n;
            n = (s >= 6) ? (s - 6 + 8) : (s + 2);
            expq.push_back({8'h40 + 8'(s), 8'h30 + 8'(n)});
        end
        commit_and_check(8'h40);

        // R6 R8: aborted transaction writes nothing
        load(8'h80, 8'h11);
        load(8'h33, 8'h22);
        pulse_abort();
        chk(ptr == 8'h82, "R6", "pointer after abort", int'(ptr), 8'h82);
        pulse_commit();
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R8", "empty commit keeps idle", int'(busy), 0);

        // R7: strobes during busy have no effect
        load(8'h05, 8'h77);
        expq.push_back({8'h05, 8'h77});
        busy_seen = 0;
        pulse_commit();
        load(8'h60, 8'hEE);
        pulse_abort();
        pulse_commit();
        wait_idle();
        chk(busy_seen == CYC, "R7", "window not extended", busy_seen, CYC);
        chk(expq.size() == 0, "R7", "pending write lost", expq.size(), 0);
        chk(ptr == 8'h06, "R7", "load while busy ignored", int'(ptr), 8'h06);
        pulse_commit();
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R7", "no byte latched while busy", int'(busy), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule